// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block supplies the column address for every beat of a synchronous DRAM burst. A controller pulses `start` together with the starting column, a burst-length code and a beat-order select. From the next clock on, the block presents one column per cycle on `col`, holds `valid` high while the burst runs, and raises `last` on the final beat of a fixed-length burst.

Beats follow one of two orders. In sequential order the low bits count upward inside the aligned block. In interleaved order the low bits are the starting low bits XORed with the beat index. A full-page setting walks the whole column space in sequential order, wraps from the top column to zero, and runs until it is ended. The `stop` input stands for either a burst-stop or a precharge and ends the burst at once. A fresh `start` may arrive on any clock and restarts the sequence. When the single-write option is on, write bursts are cut to one beat and reads keep the programmed length.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held, and on the first cycle after it, `valid` and `last` are 0.
- R2: A `start` sampled on a clock edge makes `valid`=1 and `col`=`start_col` after that edge. A `start` arriving during a running burst abandons it and begins the new burst at once.
- R3: `len_code` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. `last` is 1 only on the final beat of a fixed-length burst, and `valid` is 0 on the cycle after that beat unless a new `start` was given.
- R4: With `ilv_sel`=0 and length BL, the low log2(BL) bits of the beat i column equal (start low bits + i) mod BL. The upper bits equal those of `start_col`.
- R5: With `ilv_sel`=1 and a fixed length BL, the low log2(BL) bits of the beat i column equal the start low bits XOR i. The upper bits equal those of `start_col`.
- R6: A full-page burst is sequential whatever `ilv_sel` is. Beat i has column (`start_col` + i) mod 256, it wraps from 255 to 0, `last` never rises, and the burst runs until `stop` or a new `start`.
- R7: A `stop` sampled without `start` makes `valid` and `last` 0 after that edge. When `start` and `stop` are sampled together, the new burst begins.
- R8: When `single_wr`=1 and `is_write`=1 at `start`, the burst is one beat long whatever `len_code` is. Reads, and writes with `single_wr`=0, keep the programmed length.
- R9: The unused `len_code` values 4, 5 and 6 give a one-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new burst at `start_col` |
| start_col | input | 8 | Starting column |
| len_code | input | 3 | Burst length code (see R3, R9) |
| ilv_sel | input | 1 | 1 selects interleaved beat order |
| single_wr | input | 1 | Enables single-beat writes |
| is_write | input | 1 | The burst being started is a write |
| stop | input | 1 | Burst-stop or precharge: end the burst now |
| valid | output | 1 | A burst beat is presented on `col` |
| col | output | 8 | Column address of the current beat |
| last | output | 1 | Final beat of a fixed-length burst |

## Verification
The hardest cases to reach are the wrap at the edge of the aligned block and the full-page wrap from column 255 to 0. The first needs a starting column near the top of its block. The second needs a burst that lives for hundreds of cycles. The bench starts a burst at every one of the 256 columns for each fixed length, in both orders, so every wrap position is covered. It then runs a full-page burst from column 250 with interleave requested, for 300 beats, before stopping it. Restart in the middle of a burst and the case where start and stop arrive together are driven at set beat offsets.

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             ilv_sel,
  input  logic             single_wr,
  input  logic             is_write,
  input  logic             stop,
  output logic             valid,
  output logic [COL_W-1:0] col,
  output logic             last
);

  logic             active, ilv_q, page_q;
  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic [2:0]       eff_code;
  logic [COL_W-1:0] new_mask, step_seq, step_ilv;

  assign eff_code = (single_wr && is_write) ? 3'd0 : len_code;

  always_comb begin
    case (eff_code)
      3'd1:    new_mask = COL_W'(1);
      3'd2:    new_mask = COL_W'(3);
      3'd3:    new_mask = COL_W'(7);
      3'd7:    new_mask = '1;
      default: new_mask = '0;
    endcase
  end

  assign step_seq = base_q + beat_q;
  assign step_ilv = base_q ^ beat_q;

  assign valid = active;
  assign col   = (base_q & ~mask_q) | ((ilv_q ? step_ilv : step_seq) & mask_q);
  assign last  = active && !page_q && (beat_q == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      ilv_q  <= 1'b0;
      page_q <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      base_q <= start_col;
      beat_q <= '0;
      mask_q <= new_mask;
      page_q <= (eff_code == 3'd7);
      ilv_q  <= ilv_sel && (eff_code != 3'd7);
    end else if (stop || last) begin
      active <= 1'b0;
    end else if (active) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  p_start_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (valid && col == $past(start_col)));

  p_end_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !valid);

  p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !last && !start && !stop) |=> ((col & ~mask_q) == ($past(col) & ~mask_q)));

  p_seq_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ilv_q && !last && !start && !stop) |=>
      ((col & mask_q) == (($past(col) + 1'b1) & mask_q)));

  p_page_no_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    page_q |-> !last);

  p_page_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && page_q && col == '1 && !start && !stop) |=> (valid && col == '0));

  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> (!valid && !last));

  p_single_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && single_wr && is_write) |=> last);

endmodule

// File: tb/sdram_burst_colgen_tb_top.sv
module sdram_burst_colgen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic start = 0, ilv_sel = 0, single_wr = 0, is_write = 0, stop = 0;
  logic [7:0] start_col = 0;
  logic [2:0] len_code = 0;
  logic valid, last;
  logic [7:0] col;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_colgen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .ilv_sel(ilv_sel), .single_wr(single_wr),
    .is_write(is_write), .stop(stop), .valid(valid), .col(col), .last(last));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(input int s, input int i, input int bl, input bit ilv);
    int m = bl - 1;
    return (s & ~m & 255) | ((ilv ? (s ^ i) : (s + i)) & m);
  endfunction

  // Pulse start, then check each beat and the idle cycle after.
  task automatic burst(input int s, input int code, input bit ilv, input bit sw,
                       input bit wr, input int bl, input string req);
    @(negedge clk);
    start = 1; start_col = 8'(s); len_code = 3'(code); ilv_sel = ilv;
    single_wr = sw; is_write = wr;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < bl; i++) begin
      check(valid === 1'b1, req, int'(valid), 1);
      check(col === 8'(exp_col(s, i, bl, ilv)), req, int'(col), exp_col(s, i, bl, ilv));
      check(last === (i == bl - 1), req, int'(last), int'(i == bl - 1));
      if (i != bl - 1) @(negedge clk);
    end
    @(negedge clk);
    check(valid === 1'b0, "R3 idle after last", int'(valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid === 1'b0 && last === 1'b0, "R1 in reset", int'({valid, last}), 0);
    rst_n = 1;
    @(negedge clk);
    check(valid === 1'b0 && last === 1'b0, "R1 after reset", int'({valid, last}), 0);

    // R3 R4 R5: every start column, every fixed length, both orders
    for (int c = 0; c < 4; c++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int s = 0; s < 256; s++)
          burst(s, c, ilv[0], 0, 0, 1 << c, ilv ? "R5 interleaved" : "R4 sequential");

    // R9: unused codes give one beat
    for (int c = 4; c < 7; c++) burst(8'h37, c, 0, 0, 0, 1, "R9 unused code");

    // R8: single-write option
    burst(8'h5d, 3, 1, 1, 1, 1, "R8 write forced to one beat");
    burst(8'h5d, 3, 1, 1, 0, 8, "R8 read keeps length");
    burst(8'h5d, 2, 0, 0, 1, 4, "R8 option off write keeps length");

    // R6: full page from 250 with interleave requested, then stop (R7)
    @(negedge clk);
    start = 1; start_col = 8'd250; len_code = 3'd7; ilv_sel = 1;
    single_wr = 0; is_write = 0;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 300; i++) begin
      check(valid === 1'b1 && col === 8'((250 + i) % 256), "R6 full page col",
            int'(col), (250 + i) % 256);
      check(last === 1'b0, "R6 full page no last", int'(last), 0);
      if (i == 299) stop = 1;
      @(negedge clk);
    end
    stop = 0;
    check(valid === 1'b0 && last === 1'b0, "R7 stop ends full page", int'(valid), 0);

    // R7: stop mid fixed burst
    @(negedge clk);
    start = 1; start_col = 8'h20; len_code = 3'd3; ilv_sel = 0;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    check(col === 8'h21, "R7 beat before stop", int'(col), 8'h21);
    stop = 1;
    @(negedge clk);
    stop = 0;
    check(valid === 1'b0 && last === 1'b0, "R7 stop mid burst", int'(valid), 0);

    // R2: restart mid burst
    @(negedge clk);
    start = 1; start_col = 8'h10; len_code = 3'd3;
    @(negedge clk);
    start = 0;
    repeat (2) @(negedge clk);
    check(col === 8'h12, "R2 old burst beat 2", int'(col), 8'h12);
    start = 1; start_col = 8'h41; len_code = 3'd1; ilv_sel = 1;
    @(negedge clk);
    start = 0;
    check(valid === 1'b1 && col === 8'h41 && last === 1'b0, "R2 restart beat 0", int'(col), 8'h41);
    @(negedge clk);
    check(col === 8'h40 && last === 1'b1, "R2 restart beat 1", int'(col), 8'h40);

    // R7: start and stop together, start wins
    @(negedge clk);
    start = 1; stop = 1; start_col = 8'h99; len_code = 3'd0; ilv_sel = 0;
    @(negedge clk);
    start = 0; stop = 0;
    check(valid === 1'b1 && col === 8'h99 && last === 1'b1, "R7 start beats stop", int'(col), 8'h99);
    @(negedge clk);
    check(valid === 1'b0, "R3 idle after one beat", int'(valid), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule